// File: doc/BRIEF.md
# ADC Data Output Formatter

This block is the digital back end of a 14-bit sampling converter. On every sample clock it accepts one converted word and an over-range flag. It passes both through a fixed-length delay line and drives the result onto the output pins in one of two formats.

- **Parallel, single rate:** all data bits are driven for the whole clock period.
- **Folded, double rate:** the word is folded onto half as many pins, and each clock half carries one bit of every odd/even pair.

The block also forwards a copy of the sample clock. That forwarded clock is held low through reset and while the block starts up again after it.

Releasing reset starts a calibration interval of fixed length. While it runs, a fixed marker word replaces the data and a done flag stays low. A register interface elsewhere can read the done flag as a status bit. The format select is a static strap: it is only taken in while reset is asserted.

Top module: `adc_out_fmt`

## Requirements
- R1: A sample captured at rising clock edge N is on the data pins from edge N+LAT until edge N+LAT+1, with LAT = 10 by default. Over-range has the same delay.
- R2: In parallel mode (`ddr_sel` = 0 at reset), `dout[i]` carries bit i of the delayed word. The value is held through both halves of the clock period.
- R3: In folded mode (`ddr_sel` = 1 at reset), pin `dout[2k]` carries word bit 2k+1 while `clk` is high and word bit 2k while `clk` is low. Both bits come from the same sample.
- R4: In folded mode every odd-numbered pin `dout[2k+1]` is unused and parked at 0.
- R5: `ovr_out` carries the delayed over-range flag. In folded mode the same flag is presented in both clock halves.
- R6: `cal_done` is 0 while `rst_n` is low. It rises at the CAL_CYC-th rising clock edge after `rst_n` goes high (CAL_CYC = 40 by default) and stays 1 until the next reset.
- R7: While `cal_done` is 0, the data word is the low 14 bits of 0xCCCC (14'h0CCC), formatted per the active mode, and `ovr_out` is 0. Data appears on the same edge at which `cal_done` rises.
- R8: `fclk_out` is 0 while `rst_n` is low. From the first rising clock edge after release it follows `clk`.
- R9: The format is taken from `ddr_sel` only at clock edges while `rst_n` is low. Changes to `ddr_sel` after release have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset; its release starts calibration |
| ddr_sel | input | 1 | Format strap: 0 parallel, 1 folded double rate |
| smp_in | input | 14 | Converted sample |
| ovr_in | input | 1 | Over-range flag of the sample |
| dout | output | 14 | Formatted data pins |
| ovr_out | output | 1 | Delayed over-range flag |
| fclk_out | output | 1 | Forwarded output clock |
| cal_done | output | 1 | Calibration complete status |

## Verification
Several corner cases are targeted directly:

- **Pair order in folded mode.** A design that swapped the halves would put the even bit in the high phase. Checking both phases against the delayed sample exposes this, and so does a pipeline off by one stage.
- **Release edge.** The exact edge at which `cal_done` rises and the marker gives way to data is checked. An off-by-one counter or a marker that lingers a cycle shows up at that edge.
- **Strap changes after release.** The strap is flipped mid-stream. A design that kept following it would change format on live data.
- **Reset mid-stream.** A reset in the middle of traffic is applied. A design that forwarded the clock early or kept a stale done flag would fail there.
- **Directed extremes.** All-ones, all-zeros and alternating patterns are driven in both modes. These catch bits swapped within a pair.

// File: rtl/adc_out_fmt.sv
`timescale 1ns/1ps
module adc_out_fmt #(
  parameter int DW      = 14,
  parameter int LAT     = 10,
  parameter int CAL_CYC = 40,
  parameter logic [15:0] MARK = 16'hCCCC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ddr_sel,
  input  logic [DW-1:0] smp_in,
  input  logic          ovr_in,
  output logic [DW-1:0] dout,
  output logic          ovr_out,
  output logic          fclk_out,
  output logic          cal_done
);
  localparam int PAIRS = DW / 2;
  localparam int CW    = $clog2(CAL_CYC + 1);

  logic [DW-1:0] dly_d [LAT+1];
  logic [LAT:0]  dly_o;
  logic [CW-1:0] cal_cnt;
  logic          run, ddr_q;
  logic [DW-1:0] word;
  logic          flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAT; i++) dly_d[i] <= '0;
      dly_o <= '0;
    end else begin
      dly_d[0] <= smp_in;
      for (int i = 1; i <= LAT; i++) dly_d[i] <= dly_d[i-1];
      dly_o <= {dly_o[LAT-1:0], ovr_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_cnt  <= '0;
      cal_done <= 1'b0;
      run      <= 1'b0;
    end else begin
      run <= 1'b1;
      if (!cal_done) begin
        cal_cnt <= cal_cnt + 1'b1;
        if (cal_cnt == CW'(CAL_CYC - 1)) cal_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) ddr_q <= ddr_sel;

  assign word     = cal_done ? dly_d[LAT] : MARK[DW-1:0];
  assign flag     = cal_done & dly_o[LAT];
  assign ovr_out  = flag;
  assign fclk_out = clk & run;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign dout[2*k]   = (ddr_q && clk) ? word[2*k+1] : word[2*k];
    assign dout[2*k+1] = ddr_q ? 1'b0 : word[2*k+1];
  end
endmodule

// File: rtl/adc_out_fmt_chk.sv
`timescale 1ns/1ps
module adc_out_fmt_chk #(
  parameter int DW      = 14,
  parameter int CAL_CYC = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ddr_q,
  input logic [DW-1:0] dout,
  input logic          ovr_out,
  input logic          cal_done
);
  localparam int CW = $clog2(CAL_CYC + 1);
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since <= '0;
    else if (since != CW'(CAL_CYC)) since <= since + 1'b1;

  p_done_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done == (since == CW'(CAL_CYC)));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  p_odd_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_q |-> dout[1] == 1'b0);

  p_ovr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> !ovr_out);

  p_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_done && !ddr_q) |-> dout == 14'h0CCC);
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DW(DW), .CAL_CYC(CAL_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .ddr_q(ddr_q), .dout(dout),
  .ovr_out(ovr_out), .cal_done(cal_done)
);

// File: tb/adc_out_fmt_tb_top.sv
`timescale 1ns/1ps
module adc_out_fmt_tb_top;
  localparam int DW = 14, LAT = 10, CAL = 40, MAXE = 4096;

  logic clk = 0, rst_n = 0, ddr_sel = 0, ovr_in = 0;
  logic [DW-1:0] smp_in = '0;
  logic [DW-1:0] dout;
  logic ovr_out, fclk_out, cal_done;

  int n_run = 0, n_fail = 0, en = 0, rel = -1;
  logic mode_exp = 0;
  logic [DW:0] hist [MAXE];

  always #4 clk = ~clk;

  adc_out_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .ddr_sel(ddr_sel), .smp_in(smp_in),
    .ovr_in(ovr_in), .dout(dout), .ovr_out(ovr_out),
    .fclk_out(fclk_out), .cal_done(cal_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s edge=%0d act=%h exp=%h", tag, en, act, exp);
    end
  endtask

  function automatic bit done_now();
    return rel >= 0 && (en - rel) >= CAL;
  endfunction

  function automatic logic [DW-1:0] exp_word();
    return done_now() ? hist[en-LAT][DW-1:0] : 14'h0CCC;
  endfunction

  function automatic logic exp_ovr();
    return done_now() ? hist[en-LAT][DW] : 1'b0;
  endfunction

  function automatic logic [DW-1:0] fold(input logic [DW-1:0] w, input bit hi);
    logic [DW-1:0] r = '0;
    for (int k = 0; k < DW/2; k++) r[2*k] = hi ? w[2*k+1] : w[2*k];
    return r;
  endfunction

  task automatic step(input logic [DW-1:0] s, input logic o);
    logic [DW-1:0] w, evenmask;
    string dtag;
    smp_in = s; ovr_in = o;
    @(posedge clk);
    en++;
    hist[en] = rst_n ? {o, s} : '0;
    #2;
    w = exp_word();
    dtag = done_now() ? "R1" : "R7";
    evenmask = '0;
    for (int k = 0; k < DW/2; k++) evenmask[2*k] = 1'b1;
    chk(cal_done == done_now(), "R6 cal_done", 16'(cal_done), 16'(done_now()));
    chk(fclk_out == (rel >= 0), "R8 fclk high half", 16'(fclk_out), 16'(rel >= 0));
    chk(ovr_out == exp_ovr(), "R5 ovr high half", 16'(ovr_out), 16'(exp_ovr()));
    if (!mode_exp)
      chk(dout == w, {dtag, " R2 sdr high half"}, 16'(dout), 16'(w));
    else begin
      chk((dout & evenmask) == fold(w, 1), {dtag, " R3 ddr odd bits"}, 16'(dout & evenmask), 16'(fold(w, 1)));
      chk((dout & ~evenmask) == '0, "R4 odd pins parked", 16'(dout & ~evenmask), 16'h0);
    end
    #4;
    chk(fclk_out == 1'b0, "R8 fclk low half", 16'(fclk_out), 16'h0);
    chk(ovr_out == exp_ovr(), "R5 ovr low half", 16'(ovr_out), 16'(exp_ovr()));
    if (!mode_exp)
      chk(dout == w, {dtag, " R2 sdr low half"}, 16'(dout), 16'(w));
    else
      chk(dout == fold(w, 0), {dtag, " R3 ddr even bits"}, 16'(dout), 16'(fold(w, 0)));
  endtask

  task automatic do_reset(input int cyc, input bit mode);
    rst_n = 0; ddr_sel = mode; mode_exp = mode; rel = -1;
    #1;
    chk(cal_done == 1'b0, "R6 async clear", 16'(cal_done), 16'h0);
    chk(fclk_out == 1'b0, "R8 held in reset", 16'(fclk_out), 16'h0);
    for (int i = 0; i < cyc; i++) step('0, 1'b0);
    rst_n = 1; rel = en;
  endtask

  task automatic run_random(input int n, input bit flip);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (flip && i == 15) ddr_sel = ~ddr_sel;   // R9: strap moves after release
      if (flip && i == 70) ddr_sel = ~ddr_sel;
      step(r[DW-1:0], r[20] & r[21]);
    end
  endtask

  task automatic run_directed();
    step(14'h3FFF, 1'b1);
    step(14'h0000, 1'b0);
    step(14'h2AAA, 1'b1);
    step(14'h1555, 1'b0);
    step(14'h0001, 1'b1);
    step(14'h2000, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    #2;
    do_reset(3, 1'b0);
    run_random(CAL + 120, 1'b1);
    run_directed();
    do_reset(4, 1'b1);
    run_random(CAL + 120, 1'b1);
    run_directed();
    run_random(20, 1'b0);
    do_reset(2, 1'b0);
    run_random(CAL + LAT + 20, 1'b0);
    run_directed();
    for (int i = 0; i < LAT + 2; i++) step('0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired act=%0d exp=0", en);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule